// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Flags

This block recovers bytes from an asynchronous serial line. A frame opens with a low start bit, carries eight data bits with the least significant bit first, then one parity bit, then a high stop bit. The line is watched on every pulse of an enable input, `baud_tick`, which runs at sixteen times the bit rate. The start bit is confirmed at its midpoint. Every later bit is sampled sixteen ticks after the bit before it.

When the stop bit has been sampled, the byte is copied into a holding register and the ready flag rises. The overrun, parity-error and framing-error flags rise in the same cycle. Once set, these three flags stay set through any number of later characters. Only a separate status-clear pulse lowers them. The host reads the byte by pulsing `rd_data`, which lowers ready. A 3-bit field selects how the expected parity bit is formed, or removes the parity slot from the frame altogether.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, `rx_ready`, `ovr_err`, `par_err`, `frm_err` and `rx_byte` are all 0.
- R2: A frame is one low start bit, then D0 to D7 (LSB first), then the parity bit (unless the mode is none), then the stop bit. The received byte appears on `rx_byte` in the cycle that `rx_ready` rises.
- R3: The line is re-sampled 8 ticks after a low level is first seen. If it is high at that point, the event is a false start: the receiver returns to idle and no output changes.
- R4: `rx_ready` goes to 1 when a frame completes. A `rd_data` pulse clears it. If a completion falls in the same cycle as `rd_data`, the completion wins and `rx_ready` stays 1.
- R5: If a frame completes while `rx_ready` is 1 and `rd_data` is not asserted in that cycle, `ovr_err` is set. The new byte replaces the old one in `rx_byte`.
- R6: `par_mode` selects the expected parity bit: 0 = even (the XOR of the data bits), 1 = odd (the inverse of that XOR), 2 = always 0, 3 = always 1. A mismatch sets `par_err` in the same cycle that `rx_ready` is set.
- R7: When `par_mode[2]` is 1 (values 4 to 7), no parity bit is expected and the stop bit follows D7 directly. In this mode `par_err` is never set.
- R8: If the stop bit is sampled as 0, `frm_err` is set in the same cycle as `rx_ready`.
- R9: Once set, `ovr_err`, `par_err` and `frm_err` stay at 1 across later frames, including error-free ones, until `clr_status` is pulsed.
- R10: A `clr_status` pulse clears the three error flags and leaves `rx_ready` and `rx_byte` unchanged. If an error from a frame completing in the same cycle would set a flag, that flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Sample enable, 16 pulses per bit |
| rx_line | input | 1 | Serial input line, idles high |
| par_mode | input | 3 | Parity selection (see R6, R7) |
| rd_data | input | 1 | Pulse: host takes the held byte |
| clr_status | input | 1 | Pulse: clear the three error flags |
| rx_byte | output | 8 | Holding register |
| rx_ready | output | 1 | A byte is waiting to be read |
| ovr_err | output | 1 | Sticky overrun flag |
| par_err | output | 1 | Sticky parity-error flag |
| frm_err | output | 1 | Sticky framing-error flag |

## Verification
Two kinds of collision can fall on the same cycle as a frame completing: a host read, and a status clear. The bench counts the sample ticks of each frame it drives, so it knows the exact tick on which the stop bit is sampled. It raises `rd_data` or `clr_status` on that tick. For a read, the expected result is that ready stays set and no overrun is recorded. For a clear, an error carried by the completing frame must survive while older flags are wiped. Random frames also draw these collisions, and each outcome is judged against a reference model that applies the clear first and the completion second.

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rx_line,
  input  logic [2:0]    par_mode,
  input  logic          rd_data,
  input  logic          clr_status,
  output logic [DW-1:0] rx_byte,
  output logic          rx_ready,
  output logic          ovr_err,
  output logic          par_err,
  output logic          frm_err
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] shreg;
  logic          pbit, exp_pb, at_mid, done, pe, none;

  assign none   = par_mode[2];
  assign at_mid = baud_tick &&
                  (cnt == ((state == S_START) ? CW'(OSR/2 - 1) : CW'(OSR - 1)));
  assign done   = at_mid && (state == S_STOP);
  assign pe     = !none && (pbit != exp_pb);

  always_comb begin
    case (par_mode[1:0])
      2'd0:    exp_pb = ^shreg;
      2'd1:    exp_pb = ~^shreg;
      2'd2:    exp_pb = 1'b0;
      default: exp_pb = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (baud_tick) begin
      if (state == S_IDLE) cnt <= '0;
      else if (at_mid)     cnt <= '0;
      else                 cnt <= cnt + 1'b1;
      case (state)
        S_IDLE:  if (!rx_line) state <= S_START;
        S_START: if (at_mid) begin
          state <= rx_line ? S_IDLE : S_DATA;
          idx   <= '0;
        end
        S_DATA:  if (at_mid) begin
          shreg <= {rx_line, shreg[DW-1:1]};
          idx   <= idx + 1'b1;
          if (idx == IW'(DW - 1)) state <= none ? S_STOP : S_PAR;
        end
        S_PAR:   if (at_mid) begin
          pbit  <= rx_line;
          state <= S_STOP;
        end
        S_STOP:  if (at_mid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte  <= '0;
      rx_ready <= 1'b0;
      ovr_err  <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      if (rd_data) rx_ready <= 1'b0;
      if (clr_status) begin
        ovr_err <= 1'b0;
        par_err <= 1'b0;
        frm_err <= 1'b0;
      end
      if (done) begin
        rx_ready <= 1'b1;
        rx_byte  <= shreg;
        if (rx_ready && !rd_data) ovr_err <= 1'b1;
        if (pe)       par_err <= 1'b1;
        if (!rx_line) frm_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk (
  input logic clk,
  input logic rst_n,
  input logic par_none,
  input logic rd_data,
  input logic clr_status,
  input logic rx_ready,
  input logic ovr_err,
  input logic par_err,
  input logic frm_err
);
  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rd_data) |=> rx_ready);
  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !clr_status) |=> ovr_err);
  // R9
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !clr_status) |=> par_err);
  // R9
  frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err && !clr_status) |=> frm_err);
  // R5
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(rx_ready));
  // R6
  par_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> rx_ready);
  // R8
  frm_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_err) |-> rx_ready);
  // R7
  none_no_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_none && !par_err) |=> !par_err);
  // R10
  clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !rx_ready) |=> ((!ovr_err && !par_err && !frm_err) || rx_ready));
endmodule

bind serial_rx_status serial_rx_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .par_none(par_mode[2]), .rd_data(rd_data),
  .clr_status(clr_status), .rx_ready(rx_ready), .ovr_err(ovr_err),
  .par_err(par_err), .frm_err(frm_err)
);

// File: tb/serial_rx_status_tb_top.sv
module serial_rx_status_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic baud_tick = 1'b0, rx_line = 1'b1, rd_data = 1'b0, clr_status = 1'b0;
  logic [2:0] par_mode = 3'd0;
  logic [7:0] rx_byte;
  logic rx_ready, ovr_err, par_err, frm_err;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_byte = 8'h00;
  logic m_rdy = 1'b0, m_ovr = 1'b0, m_par = 1'b0, m_frm = 1'b0;

  always #4 clk = ~clk;

  serial_rx_status dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
    .par_mode(par_mode), .rd_data(rd_data), .clr_status(clr_status),
    .rx_byte(rx_byte), .rx_ready(rx_ready), .ovr_err(ovr_err),
    .par_err(par_err), .frm_err(frm_err)
  );

  function automatic logic exp_par(input logic [7:0] d, input int mode);
    case (mode)
      0:       return ^d;
      1:       return ~^d;
      2:       return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(rx_byte,  m_byte, {tag, " byte"});
    chk(rx_ready, m_rdy,  {tag, " ready"});
    chk(ovr_err,  m_ovr,  {tag, " ovr"});
    chk(par_err,  m_par,  {tag, " par"});
    chk(frm_err,  m_frm,  {tag, " frm"});
  endtask

  task automatic tick_once(input logic line, input logic rd, input logic clr);
    @(negedge clk);
    rx_line = line; baud_tick = 1'b1; rd_data = rd; clr_status = clr;
    @(negedge clk);
    baud_tick = 1'b0; rd_data = 1'b0; clr_status = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int mode, input bit bad_par,
                            input bit bad_stop, input bit rd_at, input bit clr_at);
    logic [10:0] bits;
    int nb, done_t;
    nb = (mode >= 4) ? 10 : 11;
    bits = '0;
    bits[8:1] = d;
    if (nb == 11) bits[9] = exp_par(d, mode) ^ bad_par;
    bits[nb-1] = !bad_stop;
    done_t = 16 * (nb - 1) + 8;
    par_mode = 3'(mode);
    for (int t = 0; t < 16 * nb; t++)
      tick_once(bits[t/16], rd_at && (t == done_t), clr_at && (t == done_t));
    if (clr_at) begin m_ovr = 0; m_par = 0; m_frm = 0; end
    if (m_rdy && !rd_at) m_ovr = 1;
    m_rdy = 1;
    m_byte = d;
    if (mode < 4 && bad_par) m_par = 1;
    if (bad_stop) m_frm = 1;
    repeat (20) tick_once(1'b1, 1'b0, 1'b0);
  endtask

  task automatic host_read();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
    m_rdy = 0;
  endtask

  task automatic host_clr();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
    m_ovr = 0; m_par = 0; m_frm = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    repeat (20) tick_once(1'b1, 1'b0, 1'b0);

    send_frame(8'hA5, 0, 0, 0, 0, 0);
    chk_all("R2 even good frame");
    host_read();
    chk(rx_ready, 0, "R4 read clears ready");
    chk(rx_byte, 8'hA5, "R4 byte kept after read");

    send_frame(8'h3C, 1, 1, 0, 1, 0);
    chk_all("R6 odd bad parity");
    host_clr();
    chk_all("R10 clear keeps ready and byte");

    send_frame(8'h81, 4, 1, 0, 0, 0);
    chk_all("R7 none mode skips parity, R5 overrun");
    host_read(); host_clr();

    send_frame(8'h5A, 2, 0, 1, 0, 0);
    chk_all("R8 bad stop");
    host_read();
    send_frame(8'h7E, 3, 0, 0, 0, 0);
    chk_all("R9 frm stays after good frame");
    host_clr();

    send_frame(8'hC3, 0, 0, 0, 1, 0);
    chk_all("R4 read collides with completion");
    chk(ovr_err, 0, "R5 no overrun on colliding read");

    tick_once(1'b0, 0, 0); tick_once(1'b0, 0, 0); tick_once(1'b0, 0, 0);
    repeat (30) tick_once(1'b1, 0, 0);
    chk_all("R3 false start ignored");
    send_frame(8'h96, 0, 0, 0, 1, 0);
    chk_all("R3 frame after false start");

    send_frame(8'h12, 1, 0, 0, 0, 0);
    chk_all("R5 overrun replaces byte");
    send_frame(8'h34, 0, 1, 0, 0, 1);
    chk_all("R10 clear collides with parity error");

    for (int i = 0; i < 40; i++) begin
      logic [7:0] d;
      int mode;
      bit bp, bs, rd_at, clr_at;
      d = 8'($urandom);
      mode = int'($urandom % 5);
      bp = ($urandom % 4) == 0;
      bs = ($urandom % 5) == 0;
      rd_at = ($urandom % 8) == 0;
      clr_at = ($urandom % 8) == 0;
      if (($urandom % 2) == 0) host_read();
      if (($urandom % 3) == 0) host_clr();
      send_frame(d, mode, bp, bs, rd_at, clr_at);
      chk_all("R2 R5 R6 R7 R8 R9 R10 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule